// File: doc/BRIEF.md
# Single-Error-Correcting Protected Word Memory

This block is a small word memory whose every stored byte carries four check bits. A write encodes the 8-bit input into a 12-bit codeword, with check bits at the power-of-two positions, and stores that codeword at the addressed row. A read fetches the addressed codeword and recomputes the check bits over it, including the stored ones, to form a 4-bit syndrome. A non-zero syndrome read as a binary number gives the position that flipped. That position is inverted before the byte is returned, whether it holds data or a check bit.

Syndromes 13 to 15 cannot come from a single flipped bit. They are flagged as uncorrectable and the byte goes out as it was stored. A test port XORs a 12-bit mask into the addressed stored codeword, so that faults can be planted deliberately.

The read result appears on the output one clock after the read request, marked by `rd_valid`. The block applies no back-pressure. Requests are accepted in every cycle and there is no ready signal. The consumer must take the result in the cycle `rd_valid` is high. Between reads the result outputs hold their last value.

Top module: `secmem_top`

## Requirements
- R1: After reset, `rd_valid`, `rdata`, `syndrome`, `err_flag` and `err_uncorr` are all 0. Every row holds the all-zero codeword, which reads back as data 0 with syndrome 0.
- R2: A byte written with `wr_en` is returned unchanged by a later read of the same row, with syndrome 0 and both flags low.
- R3: Codeword positions are numbered 1 to 12, and stored bit index p-1 holds position p. Check bits occupy positions 1, 2, 4 and 8. Data bits 7 down to 0 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Each check bit makes even the number of ones over all positions whose index has its bit set. The byte 8'hC4 is therefore stored as 12'h29C.
- R4: When a stored codeword differs from a valid one in exactly one position p (1 to 12), a read returns syndrome p, `err_flag` 1, `err_uncorr` 0, and the original byte. This holds for check-bit positions too.
- R5: A syndrome of 13, 14 or 15 gives `err_flag` 1 and `err_uncorr` 1. The data bits are returned exactly as stored, without any correction.
- R6: While `inj_en` is high, the addressed stored codeword is replaced by itself XOR `inj_mask`, and repeated injections accumulate. When `wr_en` is also high in that cycle, the stored value is the fresh codeword XOR `inj_mask`.
- R7: When a read and a write or injection hit the same row in one cycle, the read returns the contents from before that cycle.
- R8: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high. While `rd_valid` is low, `rdata`, `syndrome`, `err_flag` and `err_uncorr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Row for the read, write and injection of this cycle |
| wr_en | input | 1 | Store the encoded `wdata` at `addr` |
| wdata | input | 8 | Byte to write |
| rd_en | input | 1 | Read the row at `addr` |
| inj_en | input | 1 | XOR `inj_mask` into the stored codeword at `addr` |
| inj_mask | input | 12 | Fault mask; bit p-1 flips position p |
| rd_valid | output | 1 | Read result valid this cycle |
| rdata | output | 8 | Corrected read data |
| syndrome | output | 4 | Recomputed check value of the last read |
| err_flag | output | 1 | Last read had a non-zero syndrome |
| err_uncorr | output | 1 | Last read had a syndrome above 12 |

## Verification
A read, a write and an injection can all target the same row in the same cycle. The bench provokes this by asserting `rd_en` together with `wr_en`, with `inj_en`, and with both. The result is judged against a reference model that samples the old row before applying the update. A following read then confirms that the update, including an injected mask combined with a fresh write, was stored. Single flips at all twelve positions, and the mask pairs that yield syndromes 13 to 15, are each driven through the same path. The decoder's correction and pass-through branches are compared cycle by cycle.

// File: rtl/secmem_pkg.sv
package secmem_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [CHK_W-1:0]  syn_t;

  // position (1-based) of the j-th non-power-of-two slot
  function automatic int data_pos(input int j);
    int cnt;
    cnt = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  function automatic bit covers(input int p, input int c);
    return ((p >> c) & 1) == 1;
  endfunction

  // data bits folded into check bit c (data bit DATA_W-1-j sits at data_pos(j))
  function automatic data_t data_mask(input int c);
    data_t m;
    m = '0;
    for (int j = 0; j < DATA_W; j++)
      if (covers(data_pos(j), c)) m[DATA_W-1-j] = 1'b1;
    return m;
  endfunction

  // all codeword positions checked by syndrome bit c
  function automatic cw_t cw_mask(input int c);
    cw_t m;
    m = '0;
    for (int p = 1; p <= CW_W; p++)
      if (covers(p, c)) m[p-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/secmem_encoder.sv
module secmem_encoder
  import secmem_pkg::*;
(
  input  data_t data_i,
  output cw_t   cw_o
);
  logic [CW_W:1] pos;

  for (genvar j = 0; j < DATA_W; j++) begin : g_data
    localparam int P = data_pos(j);
    assign pos[P] = data_i[DATA_W-1-j];
  end

  for (genvar c = 0; c < CHK_W; c++) begin : g_chk
    localparam int    PP = 1 << c;
    localparam data_t M  = data_mask(c);
    assign pos[PP] = ^(data_i & M);
  end

  assign cw_o = pos;
endmodule

// File: rtl/secmem_decoder.sv
module secmem_decoder
  import secmem_pkg::*;
(
  input  cw_t   cw_i,
  output data_t data_o,
  output syn_t  syn_o,
  output logic  err_o,
  output logic  uncorr_o
);
  cw_t fixed;

  for (genvar c = 0; c < CHK_W; c++) begin : g_syn
    localparam cw_t M = cw_mask(c);
    assign syn_o[c] = ^(cw_i & M);
  end

  assign err_o    = (syn_o != '0);
  assign uncorr_o = (32'(syn_o) > CW_W);

  always_comb begin
    fixed = cw_i;
    for (int p = 1; p <= CW_W; p++)
      if (!uncorr_o && (32'(syn_o) == p)) fixed[p-1] = ~cw_i[p-1];
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_out
    localparam int P = data_pos(j);
    assign data_o[DATA_W-1-j] = fixed[P-1];
  end
endmodule

// File: rtl/secmem_store.sv
module secmem_store
  import secmem_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  cw_t               wcw,
  input  logic              inj_en,
  input  cw_t               inj_mask,
  input  logic              rd_en,
  output cw_t               rcw,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  cw_t mem [DEPTH];
  cw_t base;
  cw_t flip;

  assign base = wr_en ? wcw : mem[addr];
  assign flip = inj_en ? inj_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rcw    <= '0;
      rvalid <= 1'b0;
    end else begin
      if (wr_en || inj_en) mem[addr] <= base ^ flip;
      rvalid <= rd_en;
      if (rd_en) rcw <= mem[addr];
    end
  end
endmodule

// File: rtl/secmem_top.sv
module secmem_top
  import secmem_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  input  logic              inj_en,
  input  logic [11:0]       inj_mask,
  output logic              rd_valid,
  output logic [7:0]        rdata,
  output logic [3:0]        syndrome,
  output logic              err_flag,
  output logic              err_uncorr
);
  cw_t enc_cw;
  cw_t rd_cw;

  secmem_encoder u_enc (
    .data_i (wdata),
    .cw_o   (enc_cw)
  );

  secmem_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wcw      (enc_cw),
    .inj_en   (inj_en),
    .inj_mask (inj_mask),
    .rd_en    (rd_en),
    .rcw      (rd_cw),
    .rvalid   (rd_valid)
  );

  secmem_decoder u_dec (
    .cw_i     (rd_cw),
    .data_o   (rdata),
    .syn_o    (syndrome),
    .err_o    (err_flag),
    .uncorr_o (err_uncorr)
  );
endmodule

// File: rtl/secmem_checks.sv
module secmem_checks #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wdata,
  input logic              rd_en,
  input logic              inj_en,
  input logic [11:0]       inj_mask,
  input logic              rd_valid,
  input logic [7:0]        rdata,
  input logic [3:0]        syndrome,
  input logic              err_flag,
  input logic              err_uncorr
);
  a_r8_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r8_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rdata) && $stable(syndrome) && $stable(err_flag)));

  a_r5_uncorr_high_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (err_uncorr == (syndrome > 4'd12)));

  a_r4_flag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (err_flag == (syndrome != 4'd0)));

  a_r2_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inj_en && !rd_en) ##1 (rd_en && !wr_en && !inj_en && addr == $past(addr))
      |=> (rdata == $past(wdata, 2) && syndrome == 4'd0 && !err_flag));
endmodule

bind secmem_top secmem_checks #(.ADDR_W(ADDR_W)) u_checks (.*);

// File: tb/secmem_top_test.sv
module secmem_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, inj_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [11:0] inj_mask = '0;
  logic rd_valid, err_flag, err_uncorr;
  logic [7:0] rdata;
  logic [3:0] syndrome;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  secmem_top #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .inj_en(inj_en), .inj_mask(inj_mask),
    .rd_valid(rd_valid), .rdata(rdata), .syndrome(syndrome),
    .err_flag(err_flag), .err_uncorr(err_uncorr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [11:0] mmem [16];
  logic        e_valid = 1'b0, e_err = 1'b0, e_unc = 1'b0;
  logic [7:0]  e_data = '0;
  logic [3:0]  e_syn = '0;
  int dpos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  function automatic logic [11:0] m_encode(input logic [7:0] d);
    logic [12:1] w;
    w = '0;
    for (int k = 0; k < 8; k++) w[dpos[k]] = d[7-k];
    for (int c = 0; c < 4; c++) begin
      int ones;
      ones = 0;
      for (int p = 1; p <= 12; p++)
        if (p != (1 << c) && (p & (1 << c)) != 0 && w[p]) ones++;
      w[1 << c] = ones[0];
    end
    return w;
  endfunction

  task automatic m_read(input logic [11:0] w);
    int s;
    logic [12:1] v;
    s = 0;
    v = w;
    for (int p = 1; p <= 12; p++) if (v[p]) s = s ^ p;
    if (s >= 1 && s <= 12) v[s] = ~v[s];
    for (int k = 0; k < 8; k++) e_data[7-k] <= v[dpos[k]];
    e_syn <= s[3:0];
    e_err <= (s != 0);
    e_unc <= (s > 12);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mmem[i] <= 12'h000;
      e_valid <= 1'b0; e_data <= '0; e_syn <= '0; e_err <= 1'b0; e_unc <= 1'b0;
    end else begin
      e_valid <= rd_en;
      if (rd_en) m_read(mmem[addr]);
      if (wr_en || inj_en)
        mmem[addr] <= (wr_en ? m_encode(wdata) : mmem[addr]) ^ (inj_en ? inj_mask : 12'h000);
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("rd_valid", int'(rd_valid), int'(e_valid));
      chk("rdata", int'(rdata), int'(e_data));
      chk("syndrome", int'(syndrome), int'(e_syn));
      chk("err_flag", int'(err_flag), int'(e_err));
      chk("err_uncorr", int'(err_uncorr), int'(e_unc));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0; inj_en = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = a[AW-1:0]; wdata = d; wr_en = 1; rd_en = 0; inj_en = 0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    addr = a[AW-1:0]; wr_en = 0; rd_en = 1; inj_en = 0;
  endtask

  task automatic inj(input int a, input logic [11:0] m);
    @(negedge clk);
    addr = a[AW-1:0]; inj_mask = m; wr_en = 0; rd_en = 0; inj_en = 1;
  endtask

  // direct named checks against literal values from the requirements
  task automatic lit(input string what, input int act, input int exp);
    @(negedge clk);
    chk(what, act, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and cleared rows
    cur_req = "R1";
    idle();
    for (int a = 0; a < 16; a++) rd(a);
    idle();
    // R2: round trips with several patterns
    cur_req = "R2";
    for (int i = 0; i < 6; i++) wr(i, pats[i]);
    for (int i = 0; i < 6; i++) rd(i);
    for (int b = 0; b < 8; b++) begin wr(8 + (b % 8), 8'(1 << b)); rd(8 + (b % 8)); end
    idle();
    // R3: 0xC4 stored as 0x29C; injecting that mask leaves all-zero codeword
    cur_req = "R3";
    wr(3, 8'hC4); rd(3); idle();
    chk("literal rdata C4", int'(rdata), 8'hC4);
    inj(3, 12'h29C); rd(3); idle();
    chk("literal syndrome after cancel", int'(syndrome), 0);
    chk("literal rdata after cancel", int'(rdata), 0);
    // R4: every single-position flip, two data values
    cur_req = "R4";
    for (int p = 1; p <= 12; p++) begin
      wr(5, 8'hC4); inj(5, 12'(1 << (p - 1))); rd(5); idle();
      chk("literal syndrome", int'(syndrome), p);
      chk("literal corrected data", int'(rdata), 8'hC4);
      wr(6, 8'h3B); inj(6, 12'(1 << (p - 1))); rd(6);
    end
    idle();
    // R5: syndromes 13..15 from position pairs
    cur_req = "R5";
    wr(7, 8'h96); inj(7, 12'h801); rd(7); idle();
    chk("literal uncorr 13", int'(err_uncorr), 1);
    chk("literal raw data 13", int'(rdata), 8'h97);
    wr(7, 8'h96); inj(7, 12'h802); rd(7);
    wr(7, 8'h96); inj(7, 12'h804); rd(7);
    idle();
    // R6: accumulation and write+inject in one cycle
    cur_req = "R6";
    wr(9, 8'h42); inj(9, 12'h010); inj(9, 12'h010); rd(9);
    @(negedge clk);
    addr = 4'd10; wdata = 8'h77; inj_mask = 12'h040; wr_en = 1; inj_en = 1; rd_en = 0;
    rd(10); idle();
    chk("literal syndrome write+inject", int'(syndrome), 7);
    // R7: read together with write / injection / both on the same row
    cur_req = "R7";
    wr(11, 8'h11);
    @(negedge clk);
    addr = 4'd11; wdata = 8'h22; wr_en = 1; rd_en = 1; inj_en = 0;
    rd(11); idle();
    chk("literal new data after rw", int'(rdata), 8'h22);
    @(negedge clk);
    addr = 4'd11; inj_mask = 12'h100; wr_en = 0; rd_en = 1; inj_en = 1;
    @(negedge clk);
    addr = 4'd11; wdata = 8'h33; inj_mask = 12'h004; wr_en = 1; rd_en = 1; inj_en = 1;
    rd(11);
    idle();
    // R8: back-to-back reads, gaps, hold
    cur_req = "R8";
    rd(0); rd(11); idle(); idle(); rd(3); wr(3, 8'hEE); idle();
    repeat (3) idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule